// File: doc/BRIEF.md
# Selectable Clock Source with Fractional Rate Divider

This block turns one of ten tick streams into a slower pulse stream. Each tick stream stands for one source clock. Every input is a single-cycle tick in the system clock domain. A control word picks the source and switches the output on or off. A divisor word holds a fixed-point value with an integer field and a fractional field. For each tick of the chosen source, a phase accumulator adds one unit (2^FRAC_W). When the accumulator reaches the divisor, the block subtracts the divisor and emits a one-cycle pulse on `clk_pulse`. Over time, the pulse rate is the source rate × 2^FRAC_W / divisor.

Each instance sets its own integer width (`INT_W`) and fractional width (`FRAC_W`). The integer field always starts at bit 12 of the divisor word. The fractional field is read from the upper end of the 12-bit slot below bit 12. An instance with both widths set to zero has no divider: it forwards each tick of the chosen source as a pulse. Software writes either word through a simple write port (`wr_addr` 0 = control, 1 = divisor) and can read both back at any time.

Top module: `clksrc_fracdiv`

## Requirements
- R1: After reset, `ctrl_rd` and `div_rd` read 0 and `clk_pulse` is low.
- R2: Control word layout: bits [3:0] hold the source number and bit 4 is the output enable. A write stores only these bits. All bits other than [5:0] read as 0.
- R3: Bit 5 of `ctrl_rd` is a read-only busy flag. It always equals the stored enable bit, whatever value was written to bit 5.
- R4: `div_rd` returns the divisor word exactly as written. The effective divisor is bits [11+INT_W : 12-FRAC_W] of that word, with the integer part from bit 12 upward. All other bits have no effect on the output.
- R5: While the enable bit is 0, `clk_pulse` stays low.
- R6: Source numbers from NUM_SRC (10) to 15 select nothing, and `clk_pulse` stays low.
- R7: An effective divisor of zero keeps `clk_pulse` low.
- R8: If the effective divisor D is at least 2^FRAC_W, each selected tick adds 2^FRAC_W to the accumulator. A tick that brings the sum to D or more subtracts D and causes a pulse one cycle later. With FRAC_W=4, D=48 gives a pulse on every third tick, and D=40 (2.5) gives 8 pulses per 20 ticks.
- R9: If 0 < D < 2^FRAC_W, every selected tick produces a pulse one cycle later.
- R10: Ticks on unselected sources produce no pulse and leave the accumulator phase unchanged.
- R11: Any register write clears the accumulator. A selected tick that arrives in the same cycle as a write is discarded.
- R12: With INT_W=0 and FRAC_W=0, each selected tick while enabled produces a pulse one cycle later, and the divisor word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control word, 1 = divisor word |
| wr_data | input | 32 | Write data |
| src_tick | input | NUM_SRC | One tick line per source |
| ctrl_rd | output | 32 | Control word readback, including the busy flag |
| div_rd | output | 32 | Divisor word readback |
| clk_pulse | output | 1 | Divided pulse output |

## Verification
The bench tests the fractional phase. At D=2.5, a divider that dropped the remainder after each pulse would give 6 pulses instead of 8. It tests the case D below one unit: an accumulator that subtracted only once would grow without limit and fall out of step. It tests phase preservation across a burst of unselected ticks: a design that let those ticks reach the accumulator would pulse early or late. It also tests divisor bits outside the field window, the zero divisor, the unused source numbers, and a tick that coincides with a write. A wrong field slice, a missing zero guard or a late clear would each change the pulse count seen at the port.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
   localparam int REG_W        = 32;
   localparam int SEL_W        = 4;
   localparam int CTL_EN_BIT   = 4;
   localparam int CTL_BUSY_BIT = 5;
   localparam int INT_LSB      = 12;
   localparam int FRAC_SLOT    = 12;

   typedef enum logic {
      ADDR_CTRL = 1'b0,
      ADDR_DIV  = 1'b1
   } reg_addr_e;

   typedef struct packed {
      logic             en;
      logic [SEL_W-1:0] sel;
   } ctrl_t;
endpackage

// File: rtl/clksrc_regs.sv
module clksrc_regs
   import clksrc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [REG_W-1:0] wr_data,
   output ctrl_t            ctrl,
   output logic [REG_W-1:0] div_word,
   output logic             clr,
   output logic [REG_W-1:0] ctrl_rd
);
   ctrl_t ctrl_q;
   logic [REG_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         div_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_CTRL) begin
            ctrl_q.sel <= wr_data[SEL_W-1:0];
            ctrl_q.en  <= wr_data[CTL_EN_BIT];
         end else begin
            div_q <= wr_data;
         end
      end
   end

   always_comb begin
      ctrl_rd                  = '0;
      ctrl_rd[SEL_W-1:0]       = ctrl_q.sel;
      ctrl_rd[CTL_EN_BIT]      = ctrl_q.en;
      ctrl_rd[CTL_BUSY_BIT]    = ctrl_q.en;
   end

   assign ctrl     = ctrl_q;
   assign div_word = div_q;
   assign clr      = wr_en;

   // R3: busy flag follows the enable bit last written
   a_r3_busy_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && (wr_addr == ADDR_CTRL)) |-> (ctrl_rd[CTL_BUSY_BIT] == $past(wr_data[CTL_EN_BIT])));
endmodule

// File: rtl/clksrc_pick.sv
module clksrc_pick
   import clksrc_pkg::*;
#(
   parameter int NUM_SRC = 10
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic [NUM_SRC-1:0] src_tick,
   output logic               tick
);
   localparam int SEL_SPACE = 1 << SEL_W;

   if (NUM_SRC < 1 || NUM_SRC > SEL_SPACE) begin : g_bad_num_src
      $error("clksrc_pick: NUM_SRC must be 1..%0d", SEL_SPACE);
   end

   always_comb begin
      tick = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel == SEL_W'(i)) tick = src_tick[i];
      end
   end
endmodule

// File: rtl/clksrc_divider.sv
module clksrc_divider
   import clksrc_pkg::*;
#(
   parameter int INT_W  = 4,
   parameter int FRAC_W = 4,
   localparam int DIV_W  = INT_W + FRAC_W,
   localparam int PORT_W = (DIV_W == 0) ? 1 : DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic              tick,
   input  logic [PORT_W-1:0] div_eff,
   output logic              pulse
);
   if (FRAC_W < 0 || FRAC_W > FRAC_SLOT) begin : g_bad_frac
      $error("clksrc_divider: FRAC_W must be 0..%0d", FRAC_SLOT);
   end
   if (INT_W < 0 || INT_LSB + INT_W > REG_W) begin : g_bad_int
      $error("clksrc_divider: INT_W must be 0..%0d", REG_W - INT_LSB);
   end

   logic pulse_q;
   assign pulse = pulse_q;

   if (DIV_W == 0) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= en && tick && !clr;
      end

      // R12: pass-through pulse only follows an accepted tick
      a_r12_bypass_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
         pulse_q |-> $past(tick && en && !clr));
   end else begin : g_accum
      localparam int ACC_W = DIV_W + 1;
      localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

      logic [ACC_W-1:0] acc_q;
      logic [ACC_W-1:0] div_x;
      logic [ACC_W-1:0] sum;
      logic             div_zero;
      logic             div_small;

      always_comb begin
         div_x     = {1'b0, div_eff};
         sum       = acc_q + ONE;
         div_zero  = (div_eff == '0);
         div_small = (div_x < ONE);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q   <= '0;
            pulse_q <= 1'b0;
         end else if (clr || !en || div_zero) begin
            acc_q   <= '0;
            pulse_q <= 1'b0;
         end else if (tick) begin
            if (div_small) begin
               acc_q   <= '0;
               pulse_q <= 1'b1;
            end else if (sum >= div_x) begin
               acc_q   <= sum - div_x;
               pulse_q <= 1'b1;
            end else begin
               acc_q   <= sum;
               pulse_q <= 1'b0;
            end
         end else begin
            pulse_q <= 1'b0;
         end
      end

      // R8: phase stays below the divisor
      a_r8_acc_below_div: assert property (@(posedge clk) disable iff (!rst_n)
         (!div_zero) |-> ((acc_q < div_x) || (acc_q == '0)));
      // R7: zero divisor silences the output
      a_r7_zero_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
         div_zero |=> !pulse_q);
      // R10: a pulse always comes from an accepted selected tick
      a_r10_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
         pulse_q |-> $past(tick && en));
      // R11: a write empties the accumulator and drops any tick
      a_r11_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> ((acc_q == '0) && !pulse_q));
   end
endmodule

// File: rtl/clksrc_fracdiv.sv
module clksrc_fracdiv
   import clksrc_pkg::*;
#(
   parameter int NUM_SRC = 10,
   parameter int INT_W   = 4,
   parameter int FRAC_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [NUM_SRC-1:0] src_tick,
   output logic [31:0]        ctrl_rd,
   output logic [31:0]        div_rd,
   output logic               clk_pulse
);
   localparam int DIV_W  = INT_W + FRAC_W;
   localparam int PORT_W = (DIV_W == 0) ? 1 : DIV_W;

   ctrl_t             ctrl;
   logic [REG_W-1:0]  div_word;
   logic              clr;
   logic              sel_tick;
   logic [PORT_W-1:0] div_eff;

   clksrc_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .ctrl     (ctrl),
      .div_word (div_word),
      .clr      (clr),
      .ctrl_rd  (ctrl_rd)
   );

   clksrc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .sel      (ctrl.sel),
      .src_tick (src_tick),
      .tick     (sel_tick)
   );

   if (DIV_W == 0) begin : g_no_field
      assign div_eff = 1'b0;
   end else begin : g_field
      assign div_eff = div_word[INT_LSB-FRAC_W +: DIV_W];
   end

   clksrc_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctrl.en),
      .clr     (clr),
      .tick    (sel_tick),
      .div_eff (div_eff),
      .pulse   (clk_pulse)
   );

   assign div_rd = div_word;

   // R5: disabled output stays silent
   a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.en) |=> !clk_pulse);
   // R6: unused source numbers select nothing
   a_r6_bad_sel_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ctrl.sel) >= NUM_SRC) |=> !clk_pulse);
endmodule

// File: tb/clksrc_fracdiv_test.sv
module clksrc_fracdiv_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic [9:0]  src_tick = '0;
   logic [31:0] ctrl_rd, div_rd, ctrl_rd_bp, div_rd_bp;
   logic        clk_pulse, pulse_bp;
   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   clksrc_fracdiv #(.NUM_SRC(10), .INT_W(4), .FRAC_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .src_tick(src_tick), .ctrl_rd(ctrl_rd), .div_rd(div_rd), .clk_pulse(clk_pulse));

   clksrc_fracdiv #(.NUM_SRC(10), .INT_W(0), .FRAC_W(0)) uut_bp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .src_tick(src_tick), .ctrl_rd(ctrl_rd_bp), .div_rd(div_rd_bp), .clk_pulse(pulse_bp));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic a, input logic [31:0] d, input logic [9:0] tk = '0);
      wr_en = 1'b1; wr_addr = a; wr_data = d; src_tick = tk;
      @(negedge clk);
      wr_en = 1'b0; src_tick = '0;
   endtask

   task automatic tick(input logic [9:0] mask, output bit p, output bit pb);
      src_tick = mask;
      @(negedge clk);
      p = clk_pulse; pb = pulse_bp;
      src_tick = '0;
   endtask

   task automatic run(input logic [9:0] mask, input int n, output int cnt, output int cnt_bp);
      bit p, pb;
      cnt = 0; cnt_bp = 0;
      for (int i = 0; i < n; i++) begin
         tick(mask, p, pb);
         cnt += p; cnt_bp += pb;
      end
   endtask

   task automatic t_reset;
      check(ctrl_rd == 0, "R1 ctrl_rd after reset", ctrl_rd, 0);
      check(div_rd == 0, "R1 div_rd after reset", div_rd, 0);
      check(clk_pulse == 0, "R1 clk_pulse after reset", clk_pulse, 0);
   endtask

   task automatic t_ctrl_layout;
      wr(1'b0, 32'hFFFF_FFFF);
      check(ctrl_rd == 32'h3F, "R2 ctrl all-ones readback", ctrl_rd, 32'h3F);
      wr(1'b0, 32'h0000_0013);
      check(ctrl_rd == 32'h33, "R3 busy set with enable", ctrl_rd, 32'h33);
      wr(1'b0, 32'h0000_0022);
      check(ctrl_rd == 32'h02, "R3 busy clear, written bit5 ignored", ctrl_rd, 32'h02);
   endtask

   task automatic t_disabled;
      int c, cb;
      wr(1'b1, 32'h0000_3000);
      wr(1'b0, 32'h0000_0000);
      run(10'h001, 9, c, cb);
      check(c == 0, "R5 disabled divider output", c, 0);
      check(cb == 0, "R5 disabled bypass output", cb, 0);
   endtask

   task automatic t_period;
      bit p, pb;
      int c = 0, cb = 0;
      wr(1'b0, 32'h10);
      for (int i = 1; i <= 9; i++) begin
         tick(10'h001, p, pb);
         c += p; cb += pb;
         check(p == ((i % 3) == 0), "R8 divide-by-3 pulse position", p, (i % 3) == 0);
      end
      check(c == 3, "R8 divide-by-3 count", c, 3);
      check(cb == 9, "R12 bypass passes every tick", cb, 9);
   endtask

   task automatic t_frac;
      int c, cb;
      wr(1'b1, 32'h0000_2800);
      run(10'h001, 20, c, cb);
      check(c == 8, "R8 divide-by-2.5 count over 20 ticks", c, 8);
   endtask

   task automatic t_fast;
      int c, cb;
      wr(1'b1, 32'h0000_0800);
      run(10'h001, 7, c, cb);
      check(c == 7, "R9 divisor below one unit", c, 7);
   endtask

   task automatic t_window;
      int c, cb;
      wr(1'b1, 32'hFFF0_30FF);
      check(div_rd == 32'hFFF0_30FF, "R4 divisor word readback", div_rd, 32'hFFF0_30FF);
      run(10'h001, 9, c, cb);
      check(c == 3, "R4 bits outside field window ignored", c, 3);
   endtask

   task automatic t_zero;
      int c, cb;
      wr(1'b1, 32'hFFFF_00FF);
      run(10'h001, 8, c, cb);
      check(c == 0, "R7 zero effective divisor", c, 0);
      check(cb == 8, "R12 bypass ignores divisor", cb, 8);
   endtask

   task automatic t_unsel;
      int c, cb, c2, cb2;
      bit p, pb;
      wr(1'b1, 32'h0000_3000);
      wr(1'b0, 32'h12);
      run(10'h004, 2, c, cb);
      run(10'h3FB, 10, c2, cb2);
      check(c + c2 == 0, "R10 no pulse before phase or from other sources", c + c2, 0);
      check(cb2 == 0, "R10 bypass ignores other sources", cb2, 0);
      tick(10'h004, p, pb);
      check(p == 1, "R10 phase kept across unselected ticks", p, 1);
   endtask

   task automatic t_badsel;
      int c, cb;
      wr(1'b0, 32'h1C);
      run(10'h3FF, 6, c, cb);
      check(c == 0 && cb == 0, "R6 source 12 selects nothing", c + cb, 0);
      wr(1'b0, 32'h1A);
      run(10'h3FF, 6, c, cb);
      check(c == 0 && cb == 0, "R6 source 10 selects nothing", c + cb, 0);
   endtask

   task automatic t_clear;
      int c, cb;
      bit p, pb;
      wr(1'b1, 32'h0000_3000);
      wr(1'b0, 32'h10);
      run(10'h001, 2, c, cb);
      wr(1'b0, 32'h10);
      run(10'h001, 2, c, cb);
      check(c == 0, "R11 control write clears phase", c, 0);
      wr(1'b1, 32'h0000_3000, 10'h001);
      check(clk_pulse == 0 && pulse_bp == 0, "R11 tick during write discarded", clk_pulse + pulse_bp, 0);
      run(10'h001, 2, c, cb);
      check(c == 0, "R11 divisor write clears phase", c, 0);
      tick(10'h001, p, pb);
      check(p == 1, "R11 pulse on third tick after clear", p, 1);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl_layout();
      t_disabled();
      t_period();
      t_frac();
      t_fast();
      t_window();
      t_zero();
      t_unsel();
      t_badsel();
      t_clear();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule